// File: doc/BRIEF.md
# TLB Array and MMU Control Register Access Unit

This block holds the translation state of a memory management unit: a small instruction TLB, a larger unified TLB, an MMU control register and three staging registers for page-table entries. Software reaches all of it through a single synchronous port. A select code picks the target. For the TLB arrays, bits of the access address pick the entry, and for the unified TLB they also pick the sub-array. Write data is masked field by field before it is stored.

There is one access per cycle. A write takes effect at the next rising clock edge. Read data is combinational from the current state, so it is valid in the same cycle as the strobe. A control-register write with the invalidate bit set clears the valid flag of every entry in both TLBs. The rest of each entry stays as it was.

Top module: `tlb_array_port`

## Requirements
- R1: `acc_sel` selects the target: 0 control register, 1 staging high, 2 staging low, 3 staging assist, 4 instruction-TLB address array, 5 instruction-TLB data array, 6 unified-TLB address array, 7 unified-TLB data array. While `acc_en`=1 and `acc_wr`=0, `acc_rdata` shows the selected word in the same cycle. In every other cycle `acc_rdata` is 0. A read changes no state.
- R2: After reset every readable word is 0: the control register, the staging registers and every field of every entry.
- R3: The instruction TLB has 4 entries, indexed by `acc_addr[8:7]`. An address-array write stores the page number from `wdata[31:10]`, the valid flag from bit 8 and the process id from bits [7:0]. An address-array read returns these fields at the same positions, so the read equals `wdata & 0xFFFFFDFF`.
- R4: An instruction-TLB data-array write stores `wdata & 0x1FFFFDDA`, and a read returns that word. Bit 8 of the data word and bit 8 of the address word are the same valid flag, so a write to either array changes what both arrays read at bit 8.
- R5: The unified TLB has 64 entries, indexed by `acc_addr[13:8]`. An address-array write with `acc_addr[7]`=0 stores page number [31:10], dirty flag [9], valid flag [8] and process id [7:0]. A read returns all 32 bits in that layout.
- R6: A unified-TLB address-array write with `acc_addr[7]`=1 changes nothing.
- R7: A unified-TLB data-array write with `acc_addr[23]`=0 stores `wdata & 0x1FFFFDFF` as the physical page number and flags, and a read returns that word. Flag bit 8 is the valid flag seen at address-word bit 8. Flag bit 2 is the dirty flag seen at address-word bit 9.
- R8: A unified-TLB data-array access with `acc_addr[23]`=1 reaches a secondary 4-bit field. A write stores `wdata[3:0]` and a read returns it zero-extended. It leaves the primary data word unchanged.
- R9: The control register stores a replacement counter [15:10], a boundary [23:18], an LRU field [31:26] and bits 9, 8 and 0. A read returns `wdata & 0xFCFCFF01` of the last write.
- R10: A control-register write with `wdata[2]`=1 clears the valid flag of every entry in both TLBs. All other entry fields keep their values. The same write still stores the control fields of R9, and bit 2 reads back as 0.
- R11: The staging registers store `wdata` masked with 0xFFFFFCFF (high), 0x1FFFFDFF (low) and 0x0000000F (assist), and reads return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Target select code (R1) |
| acc_addr | input | 32 | Access address; carries the entry index and the sub-array bits |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, 0 when not reading |

## Verification
Each stored field reaches the port only through a read of its own word, so a wrong index decode or mask shows up on the next read of the affected entry. An index error usually corrupts a neighbouring entry as well. Sweeping every entry with distinct patterns makes aliasing visible within one pass. The valid and dirty flags are shared between the address word and the data word, and an invalidate clears only the valid flags. A fault in either path therefore shows up as a mismatch at bit 8 or bit 9 on the first read after the write that caused it.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  localparam int unsigned VPN_W  = 22;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned PPN_W  = 19;
  localparam int unsigned FLG_W  = 9;
  localparam int unsigned AUX_W  = 4;
  localparam int unsigned FLD_W  = 6;

  localparam logic [31:0] ITLB_DATA_MASK = 32'h1FFF_FDDA;
  localparam logic [31:0] UTLB_DATA_MASK = 32'h1FFF_FDFF;
  localparam logic [31:0] STG_HI_MASK    = 32'hFFFF_FCFF;
  localparam logic [31:0] STG_LO_MASK    = 32'h1FFF_FDFF;
  localparam logic [31:0] STG_AS_MASK    = 32'h0000_000F;
  localparam int unsigned INV_BIT        = 2;
  localparam int unsigned VALID_FLG      = 8;
  localparam int unsigned DIRTY_FLG      = 2;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_STG_HI = 3'd1,
    SEL_STG_LO = 3'd2,
    SEL_STG_AS = 3'd3,
    SEL_I_ADR  = 3'd4,
    SEL_I_DAT  = 3'd5,
    SEL_U_ADR  = 3'd6,
    SEL_U_DAT  = 3'd7
  } acc_sel_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLG_W-1:0]  flg;
  } itlb_ent_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLG_W-1:0]  flg;
    logic [AUX_W-1:0]  aux;
  } utlb_ent_t;
endpackage

// File: rtl/tlbp_ctrl.sv
module tlbp_ctrl
  import tlbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic        wr_as,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] hi_rd,
  output logic [31:0] lo_rd,
  output logic [31:0] as_rd,
  output logic        inv_o
);
  logic [FLD_W-1:0] cnt_q, bnd_q, lru_q, cnt_d, bnd_d, lru_d;
  logic [2:0]       misc_q, misc_d;
  logic [31:0]      hi_q, lo_q, as_q, hi_d, lo_d, as_d;

  always_comb begin
    cnt_d  = wdata[15:10];
    bnd_d  = wdata[23:18];
    lru_d  = wdata[31:26];
    misc_d = {wdata[9:8], wdata[0]};
    hi_d   = wdata & STG_HI_MASK;
    lo_d   = wdata & STG_LO_MASK;
    as_d   = wdata & STG_AS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; bnd_q <= '0; lru_q <= '0; misc_q <= '0;
    end else if (wr_ctrl) begin
      cnt_q <= cnt_d; bnd_q <= bnd_d; lru_q <= lru_d; misc_q <= misc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (wr_hi) hi_q <= hi_d;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (wr_lo) lo_q <= lo_d;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) as_q <= '0;
    else if (wr_as) as_q <= as_d;
  end

  assign inv_o   = wr_ctrl & wdata[INV_BIT];
  assign ctrl_rd = {lru_q, 2'b00, bnd_q, 2'b00, cnt_q, misc_q[2:1], 7'b0, misc_q[0]};
  assign hi_rd   = hi_q;
  assign lo_rd   = lo_q;
  assign as_rd   = as_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_rd)); // R9
  AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_rd == ($past(wdata) & 32'hFCFC_FF01)); // R9
endmodule

// File: rtl/tlbp_itlb.sv
module tlbp_itlb
  import tlbp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_LSB = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_d,
  input  logic        inv,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rd_a,
  output logic [31:0] rd_d
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  itlb_ent_t        ent_q [ENTRIES];
  logic [IDX_W-1:0] idx;
  logic [ENTRIES-1:0] valid_vec;

  assign idx = addr[IDX_LSB +: IDX_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    itlb_ent_t nxt;
    logic      hit, en;
    assign hit = (idx == IDX_W'(i));
    assign en  = inv | ((wr_a | wr_d) & hit);
    always_comb begin
      nxt = ent_q[i];
      if (wr_a && hit) begin
        nxt.vpn            = wdata[31:10];
        nxt.asid           = wdata[7:0];
        nxt.flg[VALID_FLG] = wdata[8];
      end
      if (wr_d && hit) begin
        nxt.ppn = wdata[28:10];
        nxt.flg = wdata[8:0] & ITLB_DATA_MASK[8:0];
      end
      if (inv) nxt.flg[VALID_FLG] = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (en) ent_q[i] <= nxt;
    end
    assign valid_vec[i] = ent_q[i].flg[VALID_FLG];
  end

  assign rd_a = {ent_q[idx].vpn, 1'b0, ent_q[idx].flg[VALID_FLG], ent_q[idx].asid};
  assign rd_d = {3'b000, ent_q[idx].ppn, 1'b0, ent_q[idx].flg};

  AST_ITLB_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> valid_vec == '0); // R10
  AST_ITLB_DATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_d & ~ITLB_DATA_MASK) == 32'h0); // R4
  AST_ITLB_VALID_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a[8] == rd_d[8]); // R4
endmodule

// File: rtl/tlbp_utlb.sv
module tlbp_utlb
  import tlbp_pkg::*;
#(
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned IDX_LSB   = 8,
  parameter int unsigned ASSOC_BIT = 7,
  parameter int unsigned AUX_BIT   = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_d,
  input  logic        inv,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rd_a,
  output logic [31:0] rd_d
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  utlb_ent_t          ent_q [ENTRIES];
  logic [IDX_W-1:0]   idx;
  logic               assoc, aux_sel;
  logic [ENTRIES-1:0] valid_vec;

  assign idx     = addr[IDX_LSB +: IDX_W];
  assign assoc   = addr[ASSOC_BIT];
  assign aux_sel = addr[AUX_BIT];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    utlb_ent_t nxt;
    logic      hit, en;
    assign hit = (idx == IDX_W'(i));
    assign en  = inv | ((wr_a | wr_d) & hit);
    always_comb begin
      nxt = ent_q[i];
      if (wr_a && hit && !assoc) begin
        nxt.vpn            = wdata[31:10];
        nxt.asid           = wdata[7:0];
        nxt.flg[VALID_FLG] = wdata[8];
        nxt.flg[DIRTY_FLG] = wdata[9];
      end
      if (wr_d && hit) begin
        if (aux_sel) begin
          nxt.aux = wdata[AUX_W-1:0];
        end else begin
          nxt.ppn = wdata[28:10];
          nxt.flg = wdata[8:0];
        end
      end
      if (inv) nxt.flg[VALID_FLG] = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (en) ent_q[i] <= nxt;
    end
    assign valid_vec[i] = ent_q[i].flg[VALID_FLG];
  end

  assign rd_a = {ent_q[idx].vpn, ent_q[idx].flg[DIRTY_FLG], ent_q[idx].flg[VALID_FLG],
                 ent_q[idx].asid};
  assign rd_d = aux_sel ? {{(32-AUX_W){1'b0}}, ent_q[idx].aux}
                        : {3'b000, ent_q[idx].ppn, 1'b0, ent_q[idx].flg};

  AST_UTLB_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> valid_vec == '0); // R10
  AST_ASSOC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && assoc) |=> ent_q[$past(idx)] == $past(ent_q[idx])); // R6
  AST_AUX_KEEPS_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && aux_sel) |=> {ent_q[$past(idx)].ppn, ent_q[$past(idx)].flg}
                          == $past({ent_q[idx].ppn, ent_q[idx].flg})); // R8
endmodule

// File: rtl/tlb_array_port.sv
module tlb_array_port
  import tlbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [2:0]  acc_sel,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata
);
  acc_sel_e    sel;
  logic        wr, rd, inv;
  logic [31:0] ctrl_rd, hi_rd, lo_rd, as_rd, ia_rd, id_rd, ua_rd, ud_rd;

  assign sel = acc_sel_e'(acc_sel);
  assign wr  = acc_en & acc_wr;
  assign rd  = acc_en & ~acc_wr;

  tlbp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr && sel == SEL_CTRL), .wr_hi(wr && sel == SEL_STG_HI),
    .wr_lo(wr && sel == SEL_STG_LO), .wr_as(wr && sel == SEL_STG_AS),
    .wdata(acc_wdata), .ctrl_rd(ctrl_rd), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .as_rd(as_rd), .inv_o(inv)
  );

  tlbp_itlb #(.ENTRIES(4), .IDX_LSB(7)) u_itlb (
    .clk(clk), .rst_n(rst_n),
    .wr_a(wr && sel == SEL_I_ADR), .wr_d(wr && sel == SEL_I_DAT), .inv(inv),
    .addr(acc_addr), .wdata(acc_wdata), .rd_a(ia_rd), .rd_d(id_rd)
  );

  tlbp_utlb #(.ENTRIES(64), .IDX_LSB(8), .ASSOC_BIT(7), .AUX_BIT(23)) u_utlb (
    .clk(clk), .rst_n(rst_n),
    .wr_a(wr && sel == SEL_U_ADR), .wr_d(wr && sel == SEL_U_DAT), .inv(inv),
    .addr(acc_addr), .wdata(acc_wdata), .rd_a(ua_rd), .rd_d(ud_rd)
  );

  always_comb begin
    acc_rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_CTRL:   acc_rdata = ctrl_rd;
        SEL_STG_HI: acc_rdata = hi_rd;
        SEL_STG_LO: acc_rdata = lo_rd;
        SEL_STG_AS: acc_rdata = as_rd;
        SEL_I_ADR:  acc_rdata = ia_rd;
        SEL_I_DAT:  acc_rdata = id_rd;
        SEL_U_ADR:  acc_rdata = ua_rd;
        SEL_U_DAT:  acc_rdata = ud_rd;
        default:    acc_rdata = '0;
      endcase
    end
  end

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> acc_rdata == 32'h0); // R1
  AST_STAGING_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd & ~STG_HI_MASK) == 0 && (lo_rd & ~STG_LO_MASK) == 0
    && (as_rd & ~STG_AS_MASK) == 0); // R11
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> $stable(ctrl_rd) && $stable(hi_rd) && $stable(lo_rd) && $stable(as_rd)); // R1
endmodule

// File: tb/tb_tlb_array_port.sv
module tb_tlb_array_port;
  localparam time CLK_P = 8ns;

  logic        clk, rst_n, acc_en, acc_wr;
  logic [2:0]  acc_sel;
  logic [31:0] acc_addr, acc_wdata, acc_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] ia_m [4];
  logic [31:0] id_m [4];
  logic [31:0] ua_m [64];
  logic [31:0] ud_m [64];
  logic [31:0] ux_m [64];

  tlb_array_port dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [31:0] pat(int i, int k);
    return (32'(i) * 32'h9E37_79B1) ^ (32'(k) * 32'h7F4A_7C15) ^ 32'h5A5A_A5A5;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_sel = s; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(logic [2:0] s, logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_sel = s; acc_addr = a; acc_wdata = 32'hDEAD_BEEF;
    #2 v = acc_rdata;
    @(posedge clk); #1;
    acc_en = 0;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(3'd4, 32'(i) << 7, v); chk({req, " itlb addr"}, v, ia_m[i]);
      rd(3'd5, 32'(i) << 7, v); chk({req, " itlb data"}, v, id_m[i]);
    end
    for (int i = 0; i < 64; i++) begin
      rd(3'd6, 32'(i) << 8, v);                 chk({req, " utlb addr"}, v, ua_m[i]);
      rd(3'd7, 32'(i) << 8, v);                 chk({req, " utlb data"}, v, ud_m[i]);
      rd(3'd7, (32'(i) << 8) | 32'h0080_0000, v); chk({req, " utlb aux"}, v, ux_m[i]);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    acc_en = 0; acc_wr = 0; acc_sel = 0; acc_addr = 0; acc_wdata = 0;
    rst_n = 0;
    for (int i = 0; i < 4; i++) begin ia_m[i] = 0; id_m[i] = 0; end
    for (int i = 0; i < 64; i++) begin ua_m[i] = 0; ud_m[i] = 0; ux_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R2: reset state
    for (int s = 0; s < 4; s++) begin
      rd(3'(s), 0, v); chk("R2 reg", v, 0);
    end
    check_all("R2");

    // R11: staging masks
    wr(3'd1, 0, 32'hFFFF_FFFF); wr(3'd2, 0, 32'hFFFF_FFFF); wr(3'd3, 0, 32'hFFFF_FFFF);
    rd(3'd1, 0, v); chk("R11 hi", v, 32'hFFFF_FCFF);
    rd(3'd2, 0, v); chk("R11 lo", v, 32'h1FFF_FDFF);
    rd(3'd3, 0, v); chk("R11 as", v, 32'h0000_000F);
    for (int k = 0; k < 8; k++) begin
      w = pat(k, 11);
      wr(3'd1, 0, w); rd(3'd1, 0, v); chk("R11 hi pat", v, w & 32'hFFFF_FCFF);
      wr(3'd2, 0, w); rd(3'd2, 0, v); chk("R11 lo pat", v, w & 32'h1FFF_FDFF);
      wr(3'd3, 0, w); rd(3'd3, 0, v); chk("R11 as pat", v, w & 32'h0000_000F);
    end

    // R9: control register fields, invalidate bit clear in data
    wr(3'd0, 0, 32'hFFFF_FFFB);
    rd(3'd0, 0, v); chk("R9 ctrl ones", v, 32'hFCFC_FF01);
    for (int k = 0; k < 8; k++) begin
      w = pat(k, 5) & ~32'h4;
      wr(3'd0, 0, w); rd(3'd0, 0, v); chk("R9 ctrl pat", v, w & 32'hFCFC_FF01);
    end

    // R1: no read strobe -> rdata zero
    @(negedge clk); acc_en = 0; acc_sel = 3'd0; #2 chk("R1 idle", acc_rdata, 0);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_sel = 3'd1; acc_wdata = 32'h1234_5678;
    #2 chk("R1 write cycle", acc_rdata, 0);
    @(posedge clk); #1 acc_en = 0; acc_wr = 0;

    // R3/R4: instruction TLB, index from addr[8:7], other addr bits junk
    for (int i = 0; i < 4; i++) begin
      w = pat(i, 1);
      wr(3'd4, (32'(i) << 7) | 32'hFFFF_FE7F & 32'h0000_0240 | 32'h0000_0240, w);
      ia_m[i] = w & 32'hFFFF_FDFF;
      id_m[i] = (id_m[i] & ~32'h100) | (w & 32'h100);
    end
    for (int i = 0; i < 4; i++) begin
      w = pat(i, 2);
      wr(3'd5, (32'(i) << 7) | 32'h0000_0040, w);
      id_m[i] = w & 32'h1FFF_FDDA;
      ia_m[i] = (ia_m[i] & ~32'h100) | (w & 32'h100);
    end
    check_all("R3 R4");
    for (int i = 0; i < 4; i++) begin
      w = pat(i, 3) ^ 32'h100;
      wr(3'd4, 32'(i) << 7, w);
      ia_m[i] = w & 32'hFFFF_FDFF;
      id_m[i] = (id_m[i] & ~32'h100) | (w & 32'h100);
      rd(3'd5, 32'(i) << 7, v); chk("R4 shared valid", v, id_m[i]);
      rd(3'd4, 32'(i) << 7, v); chk("R3 addr", v, ia_m[i]);
    end

    // R5/R7/R8: unified TLB sweep
    for (int i = 0; i < 64; i++) begin
      w = pat(i, 4);
      wr(3'd6, 32'(i) << 8, w);
      ua_m[i] = w;
      ud_m[i] = (ud_m[i] & ~32'h104) | (w & 32'h100) | ((w >> 7) & 32'h4);
    end
    check_all("R5");
    for (int i = 0; i < 64; i++) begin
      w = pat(i, 6);
      wr(3'd7, (32'(i) << 8) | 32'h0080_0000, w);
      ux_m[i] = w & 32'hF;
      if (i % 2 == 0) begin
        w = pat(i, 7);
        wr(3'd7, 32'(i) << 8, w);
        ud_m[i] = w & 32'h1FFF_FDFF;
        ua_m[i] = (ua_m[i] & ~32'h300) | (w & 32'h100) | ((w & 32'h4) << 7);
      end
    end
    check_all("R7 R8");

    // R6: associative writes ignored
    for (int i = 0; i < 64; i++) wr(3'd6, (32'(i) << 8) | 32'h80, pat(i, 9));
    check_all("R6");

    // R10: invalidate with control fields
    w = pat(3, 8) | 32'h4;
    wr(3'd0, 0, w);
    rd(3'd0, 0, v); chk("R10 ctrl stored", v, w & 32'hFCFC_FF01);
    for (int i = 0; i < 4; i++) begin ia_m[i] &= ~32'h100; id_m[i] &= ~32'h100; end
    for (int i = 0; i < 64; i++) begin ua_m[i] &= ~32'h100; ud_m[i] &= ~32'h100; end
    check_all("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule